// File: doc/BRIEF.md
# Energy Pulse Frequency Scaler

The block turns a train of single-cycle strobes into a slower train of fixed-width output pulses. Each strobe stands for one least-significant step of accumulated energy. A calibration rig watches the output wire, for example through an optical isolator. Under a steady load the output rate therefore tracks active power. Two 12-bit unsigned settings, a numerator and a denominator, set the scale factor. On average the block gives (numerator'+1) output pulses for every (denominator'+1) strobes. Here x' is the setting with zero replaced by one.

Inside, a phase accumulator adds the effective numerator on every strobe. When the sum reaches the effective denominator, the accumulator subtracts that denominator and requests a pulse. A numerator larger than the denominator is clamped, so each strobe gives exactly one pulse. A pulse generator drives the output high for `PULSE_W` cycles. It then holds the output low for at least `GAP_W` cycles. Requests that arrive while it is busy wait in a saturating counter. The settings are read on each strobe, and the accumulator residue is kept when they change.

Top module: `epfs_scaler`

## Requirements
- R1: A numerator or denominator setting of zero behaves exactly like a setting of one (num 0 and num 1 give the same pulse count; num 0 with den 0 gives one pulse per strobe).
- R2: With effective numerator n = max(num,1)+1 and effective denominator d = max(den,1)+1, where n <= d, k*d strobes starting from an empty accumulator produce exactly k*n output pulses (the smallest ratio, num 1 with den 4095, gives one pulse per 2048 strobes).
- R3: When n > d the ratio is clamped to one, so every strobe produces exactly one output pulse.
- R4: The settings are sampled on the clock edge that samples a strobe, and changing them never clears the accumulator residue (num 1/den 3 then num 2/den 4 gives its first pulse on the second strobe).
- R5: Every output pulse is high for exactly `PULSE_W` consecutive clock cycles.
- R6: Between two output pulses the output stays low for at least `GAP_W` cycles. When requests are queued the gap is exactly `GAP_W` cycles.
- R7: Pulse requests that arrive while the output is busy are queued up to 2^`PEND_W`-1 deep and never wrap. Requests beyond that depth are dropped. After the strobes stop, a full queue drains as exactly 2^`PEND_W`-1 further pulses.
- R8: When the block is idle and nothing is queued, a strobe that completes a pulse request drives `pulse_o` high from the same clock edge that samples the strobe.
- R9: An active-low reset clears the accumulator, the queue and the output, and no pulse appears later because of state from before the reset.
- R10: With `strobe_i` low, changes to the settings have no effect: no pulse starts unless a request is already queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One energy step per cycle high |
| num_i | input | 12 | Numerator setting, unsigned |
| den_i | input | 12 | Denominator setting, unsigned |
| pulse_o | output | 1 | Scaled calibration pulse output |

## Verification
A corrupted accumulator residue does not show at the ports right away. It shifts when the next pulse appears, so the error is visible only within at most one ratio period of strobes. The long-run counts in each ratio scenario pin it down exactly. A wrong queue count or a wrong timer phase shows within a single pulse period, as an extra pulse, a missing pulse or a wrong width. The per-cycle reference comparison catches these on the cycle where they occur. A queue that wraps, or a lost request, shows only when the strobes stop and the drain count comes up short.

// File: rtl/epfs_pkg.sv
package epfs_pkg;
  localparam int unsigned REG_W = 12;
  typedef logic [REG_W-1:0] ratio_reg_t;
  typedef logic [REG_W:0]   ratio_eff_t;
  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} pulse_phase_e;
endpackage

// File: rtl/epfs_ratio_norm.sv
module epfs_ratio_norm
  import epfs_pkg::*;
(
  input  ratio_reg_t num_i,
  input  ratio_reg_t den_i,
  output ratio_eff_t step_o,
  output ratio_eff_t mod_o
);
  ratio_eff_t num_eff, den_eff;

  // zero setting behaves as one; then +1
  always_comb begin
    num_eff = (num_i == '0) ? ratio_eff_t'(2) : ({1'b0, num_i} + ratio_eff_t'(1));
    den_eff = (den_i == '0) ? ratio_eff_t'(2) : ({1'b0, den_i} + ratio_eff_t'(1));
  end

  // ratio above one clamps to unity
  assign step_o = (num_eff > den_eff) ? den_eff : num_eff;
  assign mod_o  = den_eff;
endmodule

// File: rtl/epfs_phase_acc.sv
module epfs_phase_acc
  import epfs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  ratio_eff_t step_i,
  input  ratio_eff_t mod_i,
  output logic       fire_o
);
  ratio_reg_t acc_q, acc_d;
  ratio_eff_t sum, diff;

  always_comb begin
    sum    = {1'b0, acc_q} + step_i;
    diff   = sum - mod_i;
    fire_o = strobe_i && (sum >= mod_i);
    acc_d  = acc_q;
    // residue stays below 2^REG_W since step <= mod
    if (fire_o)        acc_d = diff[REG_W-1:0];
    else if (strobe_i) acc_d = sum[REG_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  // R2: a fire never leaves the residue larger than before it
  a_r2_residue_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (acc_q <= $past(acc_q)));
endmodule

// File: rtl/epfs_pulse_gen.sv
module epfs_pulse_gen
  import epfs_pkg::*;
#(
  parameter int unsigned PULSE_W = 4,
  parameter int unsigned GAP_W   = 4,
  parameter int unsigned PEND_W  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pend_empty_o,
  output logic pulse_o
);
  localparam int unsigned TMAX  = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
  localparam int unsigned CNT_W = $clog2(TMAX + 1);
  localparam logic [CNT_W-1:0]  HI_LOAD  = CNT_W'(PULSE_W - 1);
  localparam logic [CNT_W-1:0]  LO_LOAD  = CNT_W'(GAP_W - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  pulse_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              ready, take;

  assign ready = (phase_q == PH_IDLE) || ((phase_q == PH_LOW) && (cnt_q == '0));
  assign take  = ready && (req_i || (pend_q != '0));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (take) begin
      phase_d = PH_HIGH;
      cnt_d   = HI_LOAD;
    end else begin
      case (phase_q)
        PH_HIGH: begin
          if (cnt_q == '0) begin
            phase_d = PH_LOW;
            cnt_d   = LO_LOAD;
          end else cnt_d = cnt_q - 1'b1;
        end
        PH_LOW: begin
          if (cnt_q == '0) phase_d = PH_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    pend_d = pend_q;
    case ({req_i, take})
      2'b10:   if (pend_q != PEND_MAX) pend_d = pend_q + 1'b1;
      2'b01:   pend_d = pend_q - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pend_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign pulse_o      = (phase_q == PH_HIGH);
  assign pend_empty_o = (pend_q == '0);

  // run-length monitors for the width and gap checks
  logic [15:0] hi_run_q, lo_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= '0;
      lo_run_q <= 16'(GAP_W);
    end else if (pulse_o) begin
      hi_run_q <= hi_run_q + 1'b1;
      lo_run_q <= '0;
    end else begin
      hi_run_q <= '0;
      if (lo_run_q != 16'hFFFF) lo_run_q <= lo_run_q + 1'b1;
    end
  end

  a_r5_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> (hi_run_q == 16'(PULSE_W)));

  a_r6_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> (lo_run_q >= 16'(GAP_W)));

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, pend_q} == {1'b0, $past(pend_q)}) ||
    ({1'b0, pend_q} == {1'b0, $past(pend_q)} + 1'b1) ||
    ({1'b0, pend_q} + 1'b1 == {1'b0, $past(pend_q)}));
endmodule

// File: rtl/epfs_scaler.sv
module epfs_scaler
  import epfs_pkg::*;
#(
  parameter int unsigned PULSE_W = 4,
  parameter int unsigned GAP_W   = 4,
  parameter int unsigned PEND_W  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strobe_i,
  input  logic [11:0] num_i,
  input  logic [11:0] den_i,
  output logic        pulse_o
);
  ratio_eff_t step, modv;
  logic       fire, pend_empty;

  epfs_ratio_norm u_norm (
    .num_i (num_i),
    .den_i (den_i),
    .step_o(step),
    .mod_o (modv)
  );

  epfs_phase_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .step_i  (step),
    .mod_i   (modv),
    .fire_o  (fire)
  );

  epfs_pulse_gen #(
    .PULSE_W(PULSE_W),
    .GAP_W  (GAP_W),
    .PEND_W (PEND_W)
  ) u_pulse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (fire),
    .pend_empty_o(pend_empty),
    .pulse_o     (pulse_o)
  );

  // R3: numerator at or above denominator means every strobe fires
  a_r3_unity_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && (num_i >= den_i)) |-> fire);

  a_r10_quiet_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && pend_empty) |=> !$rose(pulse_o));
endmodule

// File: tb/epfs_scaler_tb_top.sv
module epfs_scaler_tb_top;
  localparam int PW = 4, GW = 4, QW = 3;
  localparam int QMAX = (1 << QW) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, strobe_i = 1'b0;
  logic [11:0] num_i = '0, den_i = '0;
  logic pulse_o;

  int checks = 0, errors = 0, rises = 0, m_starts = 0;
  bit done = 0, cmp_en = 0;
  string tag = "R9";

  always #5 clk_i = ~clk_i;

  epfs_scaler #(.PULSE_W(PW), .GAP_W(GW), .PEND_W(QW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .num_i(num_i), .den_i(den_i), .pulse_o(pulse_o));

  // behavioural reference
  int m_acc = 0, m_hi = 0, m_lo = 0, m_q = 0;
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_acc = 0; m_hi = 0; m_lo = 0; m_q = 0;
    end else begin
      int n, d, s;
      bit f, can;
      n = ((num_i == 0) ? 1 : int'(num_i)) + 1;
      d = ((den_i == 0) ? 1 : int'(den_i)) + 1;
      if (n > d) n = d;
      f = 0;
      if (strobe_i) begin
        s = m_acc + n;
        if (s >= d) begin m_acc = s - d; f = 1; end
        else m_acc = s;
      end
      can = (m_hi == 0) && (m_lo <= 1);
      if (can && (f || m_q > 0)) begin
        m_q = m_q + int'(f) - 1;
        m_hi = PW; m_lo = 0; m_starts++;
      end else begin
        if (f && m_q < QMAX) m_q++;
        if (m_hi > 0) begin
          m_hi--;
          if (m_hi == 0) m_lo = GW;
        end else if (m_lo > 0) m_lo--;
      end
    end
  end

  bit prev = 0;
  always @(negedge clk_i) begin
    bit exp;
    exp = rst_ni && (m_hi > 0);
    if (cmp_en) begin
      checks++;
      if (pulse_o !== exp) begin
        errors++;
        $display("FAIL %s R5 R6 model: pulse_o=%0b expected %0b at %0t", tag, pulse_o, exp, $time);
      end
    end
    if (pulse_o && !prev) rises++;
    prev = pulse_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic go(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic do_reset();
    go(1); rst_ni = 0; strobe_i = 0;
    go(3); rst_ni = 1;
    go(1);
  endtask

  task automatic strobes(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      strobe_i = 1; go(1); strobe_i = 0; go(gap - 1);
    end
  endtask

  task automatic run_ratio(input int nv, input int dv, input int n, input int gap,
                           input int expv, input string req);
    int r0;
    do_reset(); num_i = 12'(nv); den_i = 12'(dv); tag = req;
    r0 = rises;
    strobes(n, gap); go(40);
    chk(rises - r0 == expv, req, rises - r0, expv);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, hi;
    go(2);
    chk(pulse_o == 0, "R9 reset", pulse_o, 0);
    rst_ni = 1; go(1); cmp_en = 1;

    // R8 latency and R5 width
    num_i = 0; den_i = 0; tag = "R8";
    @(negedge clk_i); chk(pulse_o == 0, "R8 before", pulse_o, 0);
    go(0); strobe_i = 1;
    @(posedge clk_i); #2 strobe_i = 0;
    @(negedge clk_i); chk(pulse_o == 1, "R8 latency", pulse_o, 1);
    hi = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk_i); if (pulse_o) hi++; end
    chk(hi == PW, "R5 width", hi, PW);
    go(5);

    run_ratio(2, 8, 60, 10, 20, "R2 3/9");
    run_ratio(0, 5, 30, 10, 10, "R1 num0");
    run_ratio(1, 5, 30, 10, 10, "R1 num1");
    run_ratio(0, 0, 12, 10, 12, "R1 both0");
    run_ratio(100, 10, 10, 10, 10, "R3 clamp");
    run_ratio(1, 4095, 2048, 8, 1, "R2 min");

    // R4 residue kept across setting change
    do_reset(); tag = "R4"; num_i = 1; den_i = 3; r0 = rises;
    strobes(1, 10); go(10);
    chk(rises - r0 == 0, "R4 first strobe", rises - r0, 0);
    num_i = 2; den_i = 4;
    strobes(1, 10); go(10);
    chk(rises - r0 == 1, "R4 second strobe", rises - r0, 1);

    // R7 queueing and saturation, R6 gap via model
    do_reset(); tag = "R7"; num_i = 0; den_i = 0;
    strobe_i = 1; go(40); strobe_i = 0;
    @(negedge clk_i); r0 = rises;
    go(150);
    chk(rises - r0 == QMAX, "R7 drain", rises - r0, QMAX);
    chk(rises - r0 + 0 < 40, "R7 drop", rises - r0, QMAX);

    // R10 settings change without strobe
    tag = "R10"; r0 = rises;
    num_i = 7; den_i = 9; go(20); num_i = 4095; den_i = 1; go(20);
    chk(rises == r0, "R10 no strobe", rises - r0, 0);

    // R9 reset mid-run with queue
    tag = "R9"; num_i = 0; den_i = 0;
    strobe_i = 1; go(20); strobe_i = 0; rst_ni = 0;
    @(negedge clk_i); chk(pulse_o == 0, "R9 mid reset", pulse_o, 0);
    go(2); rst_ni = 1; @(negedge clk_i); r0 = rises;
    go(100);
    chk(rises == r0, "R9 queue cleared", rises - r0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule